// File: doc/BRIEF.md
# Interrupt Enable and Mask Controller

This block keeps the interrupt enable state of a processor core and decides, at each instruction boundary, whether a pending interrupt is taken. It holds a pair of enable flip-flops. The primary one gates maskable requests. The shadow one preserves the primary's value while a non-maskable service routine runs, so that a return-from-NMI strobe can restore it. A second level of control comes from a small per-source mask register. Software loads that register only by a single-register output write to one fixed I/O port. Block-transfer output writes to that same port leave it untouched.

The core's decoder supplies strobes for enable, disable, return-from-NMI and instruction boundary. The core's sequencer reports which interrupt it has just acknowledged. In return the block gives per-source qualifiers, a prioritised accept decision with the index of the winning source, and the two flip-flop values. An enable strobe arms a one-instruction inhibit, so no maskable request is taken at the boundary that ends the enable instruction. Requests become acceptable from the boundary after that.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset both enable flip-flops read 0 and the mask register holds 4'b0001, so only the general request (bit 0) can qualify.
- R2: A single-register write (io_wr=1, io_block=0) to address 0xBB loads io_data[3:0] into the mask. Bit 0 gates the general request, bit 1 vectored source C, bit 2 vectored source B and bit 3 vectored source A. The new mask is visible from the next cycle.
- R3: A write with io_block=1, or a write to any other address, leaves the mask unchanged.
- R4: irq_ok[i] is 1 exactly when irq_req[i], mask bit i, iff1 and iff2 are all 1.
- R5: An enable strobe sets both flip-flops on the next cycle. No maskable request is taken at the first boundary after the enable strobe; one can be taken at the second.
- R6: A disable strobe clears both flip-flops on the next cycle.
- R7: Acknowledging an NMI clears iff1 and leaves iff2 unchanged.
- R8: A return-from-NMI strobe copies iff2 into iff1.
- R9: Acknowledging a maskable interrupt clears both flip-flops.
- R10: A take happens only while ins_boundary is 1. Among qualified maskable sources the highest index wins (A=3 over B=2 over C=1 over general=0). take_idx gives that index, and take_nmi=0 for a maskable take.
- R11: irq_nmi at a boundary gives take_valid=1 and take_nmi=1, whatever the flip-flops, the mask or the inhibit.
- R12: When strobes coincide, the order of precedence is NMI acknowledge, then maskable acknowledge, then disable, then enable, then return-from-NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_ei | input | 1 | Enable-interrupts instruction strobe |
| ins_di | input | 1 | Disable-interrupts instruction strobe |
| ins_retn | input | 1 | Return-from-NMI instruction strobe |
| ins_boundary | input | 1 | Instruction completes this cycle |
| ack_nmi | input | 1 | Core has accepted an NMI |
| ack_mask | input | 1 | Core has accepted a maskable interrupt |
| io_wr | input | 1 | I/O output write strobe |
| io_block | input | 1 | Write belongs to a block-transfer instruction |
| io_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| irq_req | input | 4 | Maskable request lines, index 0 general, 1 C, 2 B, 3 A |
| irq_nmi | input | 1 | Non-maskable request |
| irq_ok | output | 4 | Per-source accept qualifiers |
| take_valid | output | 1 | An interrupt is taken at this boundary |
| take_nmi | output | 1 | The taken interrupt is the NMI |
| take_idx | output | 2 | Index of the taken maskable source |
| iff1 | output | 1 | Primary enable flip-flop |
| iff2 | output | 1 | Shadow enable flip-flop |

## Verification
The bench builds the block with its defaults: four maskable sources, 8-bit address and data, the mask port at 0xBB and a reset mask of 4'b0001. With these values every priority level can be reached, and every one of the sixteen mask patterns can be loaded. Directed sequences cover enable latency, NMI save and restore, block writes and wrong-address writes. A long random phase drives coinciding strobes and compares the outputs against a behavioural model on every cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    typedef struct packed {
        logic f1;
        logic f2;
        logic inh;
    } en_state_t;

    localparam en_state_t EN_RESET = '{f1: 1'b0, f2: 1'b0, inh: 1'b0};
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int                    NUM_SRC    = 4,
    parameter int                    ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]     MASK_ADDR  = 8'hBB,
    parameter logic [NUM_SRC-1:0]    MASK_RESET = 4'b0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_block,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] mask
);
    logic [NUM_SRC-1:0] mask_d, mask_q;
    logic               hit;

    always_comb begin
        hit    = io_wr && !io_block && (io_addr == MASK_ADDR);
        mask_d = mask_q;
        if (hit) mask_d = wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= MASK_RESET;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_ei,
    input  logic ins_di,
    input  logic ins_retn,
    input  logic ins_boundary,
    input  logic ack_nmi,
    input  logic ack_mask,
    output logic f1,
    output logic f2,
    output logic inh
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ins_boundary) st_d.inh = 1'b0;
        if (ack_nmi) begin
            st_d.f1 = 1'b0;
        end else if (ack_mask) begin
            st_d.f1 = 1'b0;
            st_d.f2 = 1'b0;
        end else if (ins_di) begin
            st_d.f1 = 1'b0;
            st_d.f2 = 1'b0;
        end else if (ins_ei) begin
            st_d.f1  = 1'b1;
            st_d.f2  = 1'b1;
            st_d.inh = 1'b1;
        end else if (ins_retn) begin
            st_d.f1 = st_q.f2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EN_RESET;
        else        st_q <= st_d;
    end

    assign f1  = st_q.f1;
    assign f2  = st_q.f2;
    assign inh = st_q.inh;
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               irq_nmi,
    input  logic               f1,
    input  logic               f2,
    input  logic               inh,
    input  logic               boundary,
    output logic [NUM_SRC-1:0] ok,
    output logic               take_valid,
    output logic               take_nmi,
    output logic [IDX_W-1:0]   take_idx
);
    logic             both_on;
    logic             pick_nmi, pick_mask;
    logic [IDX_W-1:0] best;

    assign both_on = f1 & f2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign ok[g] = irq_req[g] & mask[g] & both_on;
    end

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ok[i]) best = IDX_W'(i);
        end
        pick_nmi   = boundary & irq_nmi;
        pick_mask  = boundary & !irq_nmi & !inh & (|ok);
        take_valid = pick_nmi | pick_mask;
        take_nmi   = pick_nmi;
        take_idx   = pick_mask ? best : '0;
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int                 NUM_SRC    = 4,
    parameter int                 ADDR_W     = 8,
    parameter int                 DATA_W     = 8,
    parameter logic [ADDR_W-1:0]  MASK_ADDR  = 8'hBB,
    parameter logic [NUM_SRC-1:0] MASK_RESET = 4'b0001,
    localparam int                IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_ei,
    input  logic               ins_di,
    input  logic               ins_retn,
    input  logic               ins_boundary,
    input  logic               ack_nmi,
    input  logic               ack_mask,
    input  logic               io_wr,
    input  logic               io_block,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [DATA_W-1:0]  io_data,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               irq_nmi,
    output logic [NUM_SRC-1:0] irq_ok,
    output logic               take_valid,
    output logic               take_nmi,
    output logic [IDX_W-1:0]   take_idx,
    output logic               iff1,
    output logic               iff2
);
    logic [NUM_SRC-1:0] mask_q;
    logic               inh_q;

    if (DATA_W > NUM_SRC) begin : g_hi
        logic data_hi_unused;
        assign data_hi_unused = ^io_data[DATA_W-1:NUM_SRC];
    end

    irq_mask_reg #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
        .MASK_ADDR(MASK_ADDR), .MASK_RESET(MASK_RESET)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_block(io_block),
        .io_addr(io_addr), .wr_bits(io_data[NUM_SRC-1:0]), .mask(mask_q)
    );

    irq_enable_ff u_en (
        .clk(clk), .rst_n(rst_n), .ins_ei(ins_ei), .ins_di(ins_di),
        .ins_retn(ins_retn), .ins_boundary(ins_boundary),
        .ack_nmi(ack_nmi), .ack_mask(ack_mask),
        .f1(iff1), .f2(iff2), .inh(inh_q)
    );

    irq_accept_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .irq_req(irq_req), .mask(mask_q), .irq_nmi(irq_nmi),
        .f1(iff1), .f2(iff2), .inh(inh_q), .boundary(ins_boundary),
        .ok(irq_ok), .take_valid(take_valid), .take_nmi(take_nmi),
        .take_idx(take_idx)
    );
endmodule

// File: rtl/irq_gate_checker.sv
module irq_gate_checker #(
    parameter int                NUM_SRC   = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hBB,
    localparam int               IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_ei,
    input logic               ins_di,
    input logic               ins_retn,
    input logic               ins_boundary,
    input logic               ack_nmi,
    input logic               ack_mask,
    input logic               io_wr,
    input logic               io_block,
    input logic [ADDR_W-1:0]  io_addr,
    input logic [NUM_SRC-1:0] wr_bits,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               irq_nmi,
    input logic [NUM_SRC-1:0] irq_ok,
    input logic               take_valid,
    input logic               take_nmi,
    input logic [IDX_W-1:0]   take_idx,
    input logic               iff1,
    input logic               iff2,
    input logic [NUM_SRC-1:0] mask_q
);
    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !io_block && io_addr == MASK_ADDR |=> mask_q == $past(wr_bits));

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && (io_block || io_addr != MASK_ADDR) |=> $stable(mask_q));

    assert_ok_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ok) |-> iff1 && iff2 && ((irq_ok & ~(irq_req & mask_q)) == '0));

    assert_ei_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ei && !ack_nmi && !ack_mask && !ins_di |=> iff1 && iff2);

    assert_di_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_di && !ack_nmi |=> !iff1 && !iff2);

    assert_nmi_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |=> !iff1 && iff2 == $past(iff2));

    assert_retn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_retn && !ins_ei && !ins_di && !ack_nmi && !ack_mask |=> iff1 == $past(iff2));

    assert_mask_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_mask && !ack_nmi |=> !iff1 && !iff2);

    assert_take_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> ins_boundary);

    assert_take_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid && !take_nmi |-> irq_ok[take_idx]);

    assert_nmi_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ins_boundary && irq_nmi |-> take_valid && take_nmi);
endmodule

bind irq_gate_ctrl irq_gate_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_ei(ins_ei), .ins_di(ins_di),
    .ins_retn(ins_retn), .ins_boundary(ins_boundary), .ack_nmi(ack_nmi),
    .ack_mask(ack_mask), .io_wr(io_wr), .io_block(io_block), .io_addr(io_addr),
    .wr_bits(io_data[NUM_SRC-1:0]), .irq_req(irq_req), .irq_nmi(irq_nmi),
    .irq_ok(irq_ok), .take_valid(take_valid), .take_nmi(take_nmi),
    .take_idx(take_idx), .iff1(iff1), .iff2(iff2), .mask_q(mask_q)
);

// File: tb/irq_gate_ctrl_test.sv
module irq_gate_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_ei = 0, ins_di = 0, ins_retn = 0, ins_boundary = 0;
    logic       ack_nmi = 0, ack_mask = 0;
    logic       io_wr = 0, io_block = 0;
    logic [7:0] io_addr = 0, io_data = 0;
    logic [3:0] irq_req = 0;
    logic       irq_nmi = 0;
    logic [3:0] irq_ok;
    logic       take_valid, take_nmi;
    logic [1:0] take_idx;
    logic       iff1, iff2;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    bit       m_f1, m_f2, m_inh;
    bit [3:0] m_mask;

    always #10 clk = ~clk;

    irq_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ins_ei(ins_ei), .ins_di(ins_di),
        .ins_retn(ins_retn), .ins_boundary(ins_boundary), .ack_nmi(ack_nmi),
        .ack_mask(ack_mask), .io_wr(io_wr), .io_block(io_block),
        .io_addr(io_addr), .io_data(io_data), .irq_req(irq_req),
        .irq_nmi(irq_nmi), .irq_ok(irq_ok), .take_valid(take_valid),
        .take_nmi(take_nmi), .take_idx(take_idx), .iff1(iff1), .iff2(iff2)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        ins_ei = 0; ins_di = 0; ins_retn = 0; ins_boundary = 0;
        ack_nmi = 0; ack_mask = 0; io_wr = 0; io_block = 0;
        io_addr = 0; io_data = 0; irq_nmi = 0;
    endtask

    task automatic compare_all();
        bit [3:0] e_ok;
        int e_valid, e_nmi, e_idx;
        e_ok = (m_f1 && m_f2) ? (irq_req & m_mask) : 4'b0;
        e_valid = 0; e_nmi = 0; e_idx = 0;
        if (ins_boundary && irq_nmi) begin
            e_valid = 1; e_nmi = 1;
        end else if (ins_boundary && !m_inh && e_ok != 0) begin
            e_valid = 1;
            for (int k = 0; k < 4; k++) if (e_ok[k]) e_idx = k;
        end
        check("R4 irq_ok", irq_ok, e_ok);
        check("R10 take_valid", take_valid, e_valid);
        check("R11 take_nmi", take_nmi, e_nmi);
        check("R10 take_idx", take_idx, e_idx);
        check("R12 iff1", iff1, m_f1);
        check("R12 iff2", iff2, m_f2);
    endtask

    task automatic model_update();
        if (io_wr && !io_block && io_addr == 8'hBB) m_mask = io_data[3:0];
        if (ins_boundary) m_inh = 0;
        if (ack_nmi) m_f1 = 0;
        else if (ack_mask || ins_di) begin m_f1 = 0; m_f2 = 0; end
        else if (ins_ei) begin m_f1 = 1; m_f2 = 1; m_inh = 1; end
        else if (ins_retn) m_f1 = m_f2;
    endtask

    task automatic cyc();
        #2 compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic write_mask(bit [7:0] addr, bit [7:0] data, bit blk);
        io_wr = 1; io_addr = addr; io_data = data; io_block = blk;
        cyc();
        idle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        m_f1 = 0; m_f2 = 0; m_inh = 0; m_mask = 4'b0001;
        idle();
        irq_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 iff1 after reset", iff1, 0);
        check("R1 iff2 after reset", iff2, 0);

        // R5 enable latency, R1 reset mask
        irq_req = 4'hF;
        ins_ei = 1; cyc(); idle();
        check("R5 iff1 set", iff1, 1);
        check("R5 iff2 set", iff2, 1);
        ins_boundary = 1;
        #2;
        check("R1 only general qualifies", irq_ok, 4'b0001);
        check("R5 no take at first boundary", take_valid, 0);
        cyc();
        #2;
        check("R5 take at second boundary", take_valid, 1);
        check("R5 general index", take_idx, 0);
        cyc(); idle();

        // R9 maskable acknowledge
        ack_mask = 1; cyc(); idle();
        check("R9 iff1 cleared", iff1, 0);
        check("R9 iff2 cleared", iff2, 0);

        // R2 mask load and R10 priority
        write_mask(8'hBB, 8'h0F, 0);
        ins_ei = 1; cyc(); idle();
        ins_boundary = 1; cyc();
        #2;
        check("R10 source A wins", take_idx, 3);
        cyc(); idle();
        write_mask(8'hBB, 8'hF6, 0);
        #2;
        check("R2 mask 0110", irq_ok, 4'b0110);
        ins_boundary = 1;
        #2;
        check("R10 source B over C", take_idx, 2);
        cyc(); idle();
        write_mask(8'hBB, 8'h02, 0);
        ins_boundary = 1;
        #2;
        check("R2 source C index", take_idx, 1);
        cyc(); idle();

        // R3 ignored writes
        write_mask(8'hBB, 8'h0F, 1);
        #2;
        check("R3 block write ignored", irq_ok, 4'b0010);
        write_mask(8'hBA, 8'h0F, 0);
        #2;
        check("R3 other address ignored", irq_ok, 4'b0010);

        // R7 / R8 NMI save and restore
        ack_nmi = 1; cyc(); idle();
        check("R7 iff1 cleared", iff1, 0);
        check("R7 iff2 kept", iff2, 1);
        #2;
        check("R4 no qualifier with iff1 low", irq_ok, 0);
        ins_retn = 1; cyc(); idle();
        check("R8 iff1 restored", iff1, 1);

        // R12 NMI acknowledge outranks disable
        ack_nmi = 1; ins_di = 1; cyc(); idle();
        check("R12 iff1", iff1, 0);
        check("R12 iff2 kept", iff2, 1);

        // R6 disable, R11 NMI regardless
        ins_di = 1; cyc(); idle();
        check("R6 iff1 cleared", iff1, 0);
        check("R6 iff2 cleared", iff2, 0);
        irq_nmi = 1; ins_boundary = 1;
        #2;
        check("R11 NMI taken while disabled", take_nmi, 1);
        cyc(); idle();
        ins_ei = 1; cyc(); idle();
        irq_nmi = 1; ins_boundary = 1;
        #2;
        check("R11 NMI taken during inhibit", take_valid, 1);
        cyc(); idle();

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            ins_ei       = ($urandom_range(0, 11) == 0);
            ins_di       = ($urandom_range(0, 23) == 0);
            ins_retn     = ($urandom_range(0, 11) == 0);
            ins_boundary = ($urandom_range(0, 2) == 0);
            ack_nmi      = ($urandom_range(0, 19) == 0);
            ack_mask     = ($urandom_range(0, 15) == 0);
            io_wr        = ($urandom_range(0, 5) == 0);
            io_block     = ($urandom_range(0, 3) == 0);
            io_addr      = ($urandom_range(0, 1) == 0) ? 8'hBB : 8'($urandom);
            io_data      = 8'($urandom);
            irq_req      = 4'($urandom);
            irq_nmi      = ($urandom_range(0, 9) == 0);
            cyc();
        end
        idle();

        summary();
        $finish;
    end
endmodule